// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block connects a byte-wide processor bus to three parallel ports. Two ports, A and B, are each eight bits wide. Port C is also eight bits, but its upper and lower nibbles are steered separately. The processor selects a port or the control register with two address lines. It moves data with active-low chip select, read and write strobes that are sampled on the system clock. The data bus is presented as a separate input, output and drive enable, so the chip-level pad can tri-state it.

A control word with its top bit set defines the mode. In this block only the plain, unhandshaked mode is supported, and the word sets the direction of port A, port B and each port C nibble. A control word with its top bit clear sets or clears one port C output bit and leaves every other bit of state alone. Each port pin has its own output enable. A pin set as an input is never driven. Reading an input returns the pin level at that moment, and reading an output returns its latch.

Top module: `ppi_ctrl`

## Requirements
- R1: A write is accepted on the rising clock edge where cs_n and wr_n are both low. The port addressed by addr loads data_i: 00 is port A, 01 is port B and 10 is port C. The other two port latches do not change.
- R2: A write with addr = 11 loads the control register. A read with addr = 11 keeps data_oe low.
- R3: data_oe is high only while cs_n is low, rd_n is low, wr_n is high and addr is not 11. In every other case it is low.
- R4: A control word with bit 7 = 1 sets four direction flags, where 1 means input: bit 4 for port A, bit 3 for port C bits 7..4, bit 1 for port B and bit 0 for port C bits 3..0. Bits 6, 5 and 2 have no effect.
- R5: A port or nibble set as output has all of its pin enables high. Its pin outputs show its latch, and a read of it returns the latch. A port or nibble set as input has all of its pin enables low.
- R6: A read of a port or nibble set as input returns the current pin level combinationally. The value is not held, so a pin change during the read shows on data_o at once.
- R7: The two port C nibbles follow their own direction flags. A port C read combines pin and latch values nibble by nibble.
- R8: A control word with bit 7 = 0 writes bit 0 into the port C latch bit chosen by bits 3..1. No other latch bit and no direction flag changes.
- R9: A mode-defining control word clears all three output latches to zero.
- R10: While rst is high, all four direction flags become input and all latches become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port / control select |
| data_i | input | 8 | Bus data from processor |
| data_o | output | 8 | Bus data to processor |
| data_oe | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A per-pin enables |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B per-pin enables |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C pin drive values |
| pc_oe | output | 8 | Port C per-pin enables |

## Verification
The hardest case to reach is a strobe combination that would cause a write, such as chip select and write both low, while the bench only needs to observe the bus enable. The bench applies each of the 32 combinations of select, strobes and address just after a falling clock edge. It samples the enable and removes the combination before the next rising edge, so no write is ever taken. The unlatched input path is checked by changing the pins in the middle of a read and observing data_o follow the change.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
   typedef enum logic [1:0] {
      SEL_A   = 2'b00,
      SEL_B   = 2'b01,
      SEL_C   = 2'b10,
      SEL_CTL = 2'b11
   } sel_e;

   typedef struct packed {
      logic a_in;
      logic cu_in;
      logic b_in;
      logic cl_in;
   } dir_t;

   // control word field positions decoded by the register bank
   localparam int DIR_A_POS  = 4;
   localparam int DIR_CU_POS = 3;
   localparam int DIR_B_POS  = 1;
   localparam int DIR_CL_POS = 0;
endpackage

// File: rtl/ppi_decode.sv
module ppi_decode
   import ppi_pkg::*;
(
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic [1:0] addr,
   output logic       wr_a,
   output logic       wr_b,
   output logic       wr_c,
   output logic       wr_ctl,
   output logic       bus_drive
);
   logic wr_any, rd_any;
   sel_e sel;

   always_comb begin
      sel    = sel_e'(addr);
      wr_any = !cs_n && !wr_n;
      rd_any = !cs_n && !rd_n && wr_n;
      wr_a   = wr_any && (sel == SEL_A);
      wr_b   = wr_any && (sel == SEL_B);
      wr_c   = wr_any && (sel == SEL_C);
      wr_ctl = wr_any && (sel == SEL_CTL);
      bus_drive = rd_any && (sel != SEL_CTL);
   end
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
   import ppi_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic          wr_c,
   input  logic          wr_ctl,
   input  logic [DW-1:0] din,
   output dir_t          dir,
   output logic [DW-1:0] lat_a,
   output logic [DW-1:0] lat_b,
   output logic [DW-1:0] lat_c
);
   localparam int SELW     = $clog2(DW);
   localparam int MODE_POS = DW - 1;

   generate
      if (DW < 8 || (DW % 2) != 0 || SELW + 1 >= MODE_POS) begin : g_bad_width
         $error("ppi_regs: DW must be even and at least 8");
      end
   endgenerate

   logic mode_wr, bsr_wr;
   logic [SELW-1:0] bsr_idx;

   always_comb begin
      mode_wr = wr_ctl && din[MODE_POS];
      bsr_wr  = wr_ctl && !din[MODE_POS];
      bsr_idx = din[SELW:1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dir   <= '1;
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
      end else if (mode_wr) begin
         dir   <= '{a_in: din[DIR_A_POS], cu_in: din[DIR_CU_POS],
                    b_in: din[DIR_B_POS], cl_in: din[DIR_CL_POS]};
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
      end else begin
         if (wr_a) lat_a <= din;
         if (wr_b) lat_b <= din;
         if (wr_c) lat_c <= din;
         if (bsr_wr) lat_c[bsr_idx] <= din[0];
      end
   end

   p_bsr_single_bit_r8: assert property (@(posedge clk) disable iff (rst)
      bsr_wr |=> ($countones(lat_c ^ $past(lat_c)) <= 1) && $stable(lat_a)
                 && $stable(lat_b) && $stable(dir));

   p_bsr_target_r8: assert property (@(posedge clk) disable iff (rst)
      bsr_wr |=> lat_c[$past(bsr_idx)] == $past(din[0]));

   p_mode_clears_r9: assert property (@(posedge clk) disable iff (rst)
      mode_wr |=> (lat_a == '0) && (lat_b == '0) && (lat_c == '0));

   p_single_port_r1: assert property (@(posedge clk) disable iff (rst)
      wr_a |=> $stable(lat_b) && $stable(lat_c));
endmodule

// File: rtl/ppi_pins.sv
module ppi_pins #(
   parameter int W             = 8,
   parameter bit READ_OUT_LATCH = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_dir,
   input  logic [W-1:0] lat,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] pin_o,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);
   generate
      if (W < 1) begin : g_bad_w
         $error("ppi_pins: W must be positive");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign pin_o[i]  = lat[i];
         assign pin_oe[i] = ~in_dir;
         if (READ_OUT_LATCH) begin : g_rd_lat
            assign rd_val[i] = in_dir ? pin_i[i] : lat[i];
         end else begin : g_rd_pin
            assign rd_val[i] = pin_i[i];
         end
      end
   endgenerate

   p_input_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      in_dir |-> (pin_oe == '0));
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
   import ppi_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] data_o,
   output logic          data_oe,
   input  logic [DW-1:0] pa_i,
   output logic [DW-1:0] pa_o,
   output logic [DW-1:0] pa_oe,
   input  logic [DW-1:0] pb_i,
   output logic [DW-1:0] pb_o,
   output logic [DW-1:0] pb_oe,
   input  logic [DW-1:0] pc_i,
   output logic [DW-1:0] pc_o,
   output logic [DW-1:0] pc_oe
);
   localparam int HW = DW / 2;

   logic wr_a, wr_b, wr_c, wr_ctl;
   dir_t dir;
   logic [DW-1:0] lat_a, lat_b, lat_c;
   logic [DW-1:0] rd_a, rd_b;
   logic [HW-1:0] rd_cu, rd_cl;

   ppi_decode u_dec (
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctl(wr_ctl),
      .bus_drive(data_oe)
   );

   ppi_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
      .wr_ctl(wr_ctl), .din(data_i), .dir(dir),
      .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c)
   );

   ppi_pins #(.W(DW)) u_pa (
      .clk(clk), .rst(rst), .in_dir(dir.a_in), .lat(lat_a), .pin_i(pa_i),
      .pin_o(pa_o), .pin_oe(pa_oe), .rd_val(rd_a)
   );

   ppi_pins #(.W(DW)) u_pb (
      .clk(clk), .rst(rst), .in_dir(dir.b_in), .lat(lat_b), .pin_i(pb_i),
      .pin_o(pb_o), .pin_oe(pb_oe), .rd_val(rd_b)
   );

   ppi_pins #(.W(HW)) u_pcu (
      .clk(clk), .rst(rst), .in_dir(dir.cu_in), .lat(lat_c[DW-1:HW]),
      .pin_i(pc_i[DW-1:HW]), .pin_o(pc_o[DW-1:HW]), .pin_oe(pc_oe[DW-1:HW]),
      .rd_val(rd_cu)
   );

   ppi_pins #(.W(HW)) u_pcl (
      .clk(clk), .rst(rst), .in_dir(dir.cl_in), .lat(lat_c[HW-1:0]),
      .pin_i(pc_i[HW-1:0]), .pin_o(pc_o[HW-1:0]), .pin_oe(pc_oe[HW-1:0]),
      .rd_val(rd_cl)
   );

   always_comb begin
      unique case (sel_e'(addr))
         SEL_A:   data_o = rd_a;
         SEL_B:   data_o = rd_b;
         SEL_C:   data_o = {rd_cu, rd_cl};
         default: data_o = '0;
      endcase
   end

   p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (cs_n || rd_n || !wr_n) |-> !data_oe);

   p_ctl_read_undriven_r2: assert property (@(posedge clk) disable iff (rst)
      (addr == 2'b11) |-> !data_oe);

   p_nibbles_follow_dir_r7: assert property (@(posedge clk) disable iff (rst)
      (pc_oe[DW-1:HW] == '0 || pc_oe[DW-1:HW] == '1)
      && (pc_oe[HW-1:0] == '0 || pc_oe[HW-1:0] == '1));
endmodule

// File: tb/sim_ppi_ctrl.sv
module sim_ppi_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] data_i = 8'h00;
   logic [7:0] data_o;
   logic       data_oe;
   logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
   logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model
   logic dA, dCU, dB, dCL;
   logic [7:0] mA, mB, mC;

   always #(CLK_PERIOD/2) clk = ~clk;

   ppi_ctrl u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
      .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
      .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
      .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; data_i = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      case (a)
         2'b00: mA = d;
         2'b01: mB = d;
         2'b10: mC = d;
         default: begin
            if (d[7]) begin
               dA = d[4]; dCU = d[3]; dB = d[1]; dCL = d[0];
               mA = 8'h00; mB = 8'h00; mC = 8'h00;
            end else begin
               mC[d[3:1]] = d[0];
            end
         end
      endcase
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] v,
                           output logic oe);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #1;
      v = data_o; oe = data_oe;
      #1;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   function automatic logic [7:0] exp_oe(input logic d);
      return d ? 8'h00 : 8'hFF;
   endfunction

   task automatic check_pins(input string req);
      logic [7:0] eoc;
      eoc = {exp_oe(dCU)[3:0], exp_oe(dCL)[3:0]};
      check(pa_oe == exp_oe(dA), req, pa_oe, exp_oe(dA));
      check(pb_oe == exp_oe(dB), req, pb_oe, exp_oe(dB));
      check(pc_oe == eoc, req, pc_oe, eoc);
      check(pa_o == mA && pb_o == mB && pc_o == mC, req,
            {8'h0, pa_o, pb_o, pc_o}, {8'h0, mA, mB, mC});
   endtask

   initial begin
      logic [7:0] v, ev, cw;
      logic oe;
      dA = 1; dCU = 1; dB = 1; dCL = 1; mA = 0; mB = 0; mC = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_pins("R10 reset state");

      // R3/R2: all strobe/address combinations, applied between edges
      for (int i = 0; i < 32; i++) begin
         logic eo;
         @(negedge clk);
         {cs_n, rd_n, wr_n, addr} = 5'(i);
         #1;
         eo = !cs_n && !rd_n && wr_n && (addr != 2'b11);
         check(data_oe == eo, (addr == 2'b11) ? "R2 ctl read undriven" : "R3 bus enable",
               data_oe, eo);
         #1;
         cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      end
      check_pins("R1 no write from combinational strobes");

      // sweep all 16 direction settings
      for (int m = 0; m < 16; m++) begin
         logic [3:0] mm;
         mm = 4'(m);
         bus_write(2'b00, 8'h5A ^ 8'(m));
         bus_write(2'b01, 8'hC3 ^ 8'(m));
         bus_write(2'b10, 8'h3C ^ 8'(m));
         // junk in bits 6,5,2 (R4)
         cw = {1'b1, mm[1], mm[0], mm[3], mm[2], mm[3], mm[1], mm[0]};
         bus_write(2'b11, cw);
         check_pins("R9 mode clears latches / R4 directions");
         bus_write(2'b00, 8'h11 + 8'(m * 7));
         check_pins("R1 port A write only");
         bus_write(2'b01, 8'h92 ^ 8'(m * 13));
         bus_write(2'b10, 8'hE4 - 8'(m * 3));
         check_pins("R5 output drive");
         pa_i = 8'hA0 + 8'(m); pb_i = 8'h0F ^ 8'(m << 4); pc_i = 8'h69 ^ 8'(m);
         bus_read(2'b00, v, oe);
         ev = dA ? pa_i : mA;
         check(oe && v == ev, "R5 R6 port A read", {oe, v}, {1'b1, ev});
         bus_read(2'b01, v, oe);
         ev = dB ? pb_i : mB;
         check(oe && v == ev, "R5 R6 port B read", {oe, v}, {1'b1, ev});
         bus_read(2'b10, v, oe);
         ev = {dCU ? pc_i[7:4] : mC[7:4], dCL ? pc_i[3:0] : mC[3:0]};
         check(oe && v == ev, "R7 port C mixed read", {oe, v}, {1'b1, ev});
      end

      // R6: input pins not latched
      bus_write(2'b11, 8'h9B);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = 2'b00; pa_i = 8'h12;
      #1;
      check(data_o == 8'h12, "R6 live read", data_o, 8'h12);
      pa_i = 8'hED;
      #1;
      check(data_o == 8'hED, "R6 pin change follows", data_o, 8'hED);
      cs_n = 1'b1; rd_n = 1'b1;

      // R8: bit set/reset sweep with all outputs
      bus_write(2'b11, 8'h80);
      bus_write(2'b00, 8'h77);
      bus_write(2'b01, 8'h88);
      bus_write(2'b10, 8'hA5);
      for (int b = 0; b < 8; b++) begin
         bus_write(2'b11, {4'b0000, 3'(b), 1'b1});
         check_pins("R8 bit set");
         bus_write(2'b11, {4'b0000, 3'(b), 1'b0});
         check_pins("R8 bit clear");
      end
      check(pc_o == 8'h00, "R8 all cleared", pc_o, 8'h00);

      // R10: reset mid-run
      bus_write(2'b11, 8'h80);
      bus_write(2'b10, 8'hFF);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      dA = 1; dCU = 1; dB = 1; dCL = 1; mA = 0; mB = 0; mC = 0;
      check_pins("R10 reset mid-run");

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule